// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, A and B. Each transfer direction can forward the live value on the opposite bus or a value captured earlier in that direction's own storage register. Every direction has its own output enable and its own source select. Each register is loaded on the rising edge of its own capture clock, whatever the select and enable levels are. A power-down input turns every driver off.

Each bus is modelled with three sets of signals: an external driver (value plus enable), the block's driver (value plus enable), and the resolved value seen on the wire. The resolution works as follows. An external driver has priority. If there is no external driver, the block's driver sets the value. If nothing drives the bus, it keeps the value it had at the previous system clock edge. When both directions run live and both are enabled, the two buses reinforce each other. A value placed on one bus from outside then appears on both. If neither bus is driven from outside, both keep their last state.

Top module: `reg_bus_xcvr`

## Requirements
- R1: After an active-low asynchronous reset, both storage registers and both hold states are zero. With no driver active, both resolved buses read 0.
- R2: `b_oe_o` is high only when `oe_ab_i` is high (active high). `a_oe_o` is high only when `oe_ba_ni` is low (active low). While a driver's enable is off, its value output is 0.
- R3: With select low (live), the B driver carries the resolved A value and the A driver carries the resolved B value.
- R4: With select high (stored), the B driver carries the register loaded from bus A and the A driver carries the register loaded from bus B.
- R5: A rising edge of `clk_ab_i` loads the resolved A value into the A-to-B register. A rising edge of `clk_ba_i` loads the resolved B value into the B-to-A register. Both loads happen whatever the levels of select, enable and power-down.
- R6: The resolved bus equals the external value when the external enable is high. Otherwise it equals the block's driver value when the block drives. Otherwise it equals the resolved value sampled at the previous `clk_i` rising edge.
- R7: Both directions live and enabled with exactly one bus driven externally: both resolved buses and both drivers carry that external value. With neither bus driven externally, each resolved bus keeps its previous value.
- R8: While `pd_i` is high, both output enables are low and both driver values are 0, whatever the other controls are.
- R9: A change on a select or enable input reaches the driver and bus outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; updates the bus hold state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down; forces all drivers off |
| clk_ab_i | input | 1 | Capture clock, loads bus A into the A-to-B register |
| clk_ba_i | input | 1 | Capture clock, loads bus B into the B-to-A register |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |
| sel_ab_i | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba_i | input | 1 | B-to-A source: 0 live, 1 stored |
| a_ext_i | input | 8 | External driver value on bus A |
| a_ext_en_i | input | 1 | External driver enable on bus A |
| b_ext_i | input | 8 | External driver value on bus B |
| b_ext_en_i | input | 1 | External driver enable on bus B |
| a_drv_o | output | 8 | Block's driver value onto bus A |
| a_oe_o | output | 1 | Block's driver enable onto bus A |
| a_bus_o | output | 8 | Resolved value on bus A |
| b_drv_o | output | 8 | Block's driver value onto bus B |
| b_oe_o | output | 1 | Block's driver enable onto bus B |
| b_bus_o | output | 8 | Resolved value on bus B |

## Verification
The bench runs all 128 combinations of power-down, both enables, both selects and both external enables, and checks every output before a capture, after a capture and after a system clock edge. Corner cases:
- Capture while powered down or disabled: a design that gated its registers on select or enable would later present a stale stored value.
- Both directions live with no external driver: a design that resolved this case naively would form a combinational loop or lose the held value.
- Power-down with both selects stored: a design that left one driver on would show a nonzero enable.
- Select switched between clock edges: a design with an extra output register would lag by one cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int unsigned NUM_BUS = 2;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_bus_resolve.sv
// Resolves bus x without a structural loop through bus y: when y is itself
// live-driven from x and nothing external drives either, x keeps its hold value.
module xcvr_bus_resolve #(
  parameter int unsigned W = 8
) (
  input  logic         x_ext_en_i,
  input  logic [W-1:0] x_ext_i,
  input  logic [W-1:0] x_hold_i,
  input  logic         x_oe_i,
  input  logic         x_sel_i,
  input  logic [W-1:0] x_stored_i,
  input  logic         y_ext_en_i,
  input  logic [W-1:0] y_ext_i,
  input  logic [W-1:0] y_hold_i,
  input  logic         y_oe_i,
  input  logic         y_sel_i,
  input  logic [W-1:0] y_stored_i,
  output logic [W-1:0] x_bus_o
);
  import xcvr_pkg::*;

  logic [W-1:0] y_view;

  always_comb begin
    if (y_ext_en_i)                         y_view = y_ext_i;
    else if (!y_oe_i)                       y_view = y_hold_i;
    else if (src_sel_e'(y_sel_i) == SRC_STORED) y_view = y_stored_i;
    else                                    y_view = x_hold_i;
  end

  always_comb begin
    if (x_ext_en_i)                         x_bus_o = x_ext_i;
    else if (!x_oe_i)                       x_bus_o = x_hold_i;
    else if (src_sel_e'(x_sel_i) == SRC_STORED) x_bus_o = x_stored_i;
    else                                    x_bus_o = y_view;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W = 8
) (
  input  logic         oe_i,
  input  logic         sel_i,
  input  logic [W-1:0] stored_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] drv_o
);
  import xcvr_pkg::*;

  always_comb begin
    if (!oe_i)                                drv_o = '0;
    else if (src_sel_e'(sel_i) == SRC_STORED) drv_o = stored_i;
    else                                      drv_o = live_i;
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pd_i,
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         oe_ab_i,
  input  logic         oe_ba_ni,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_ext_i,
  input  logic         a_ext_en_i,
  input  logic [W-1:0] b_ext_i,
  input  logic         b_ext_en_i,
  output logic [W-1:0] a_drv_o,
  output logic         a_oe_o,
  output logic [W-1:0] a_bus_o,
  output logic [W-1:0] b_drv_o,
  output logic         b_oe_o,
  output logic [W-1:0] b_bus_o
);
  import xcvr_pkg::*;

  // index 0 = bus A, 1 = bus B; per-bus signals describe the driver onto that bus
  logic [W-1:0] ext_w    [NUM_BUS];
  logic [W-1:0] hold_q   [NUM_BUS];
  logic [W-1:0] cap_q    [NUM_BUS];
  logic [W-1:0] stored_w [NUM_BUS];
  logic [W-1:0] bus_w    [NUM_BUS];
  logic [W-1:0] drv_w    [NUM_BUS];
  logic         ext_en_w [NUM_BUS];
  logic         oe_w     [NUM_BUS];
  logic         sel_w    [NUM_BUS];
  logic         cap_clk_w[NUM_BUS];

  assign ext_w[0]     = a_ext_i;
  assign ext_w[1]     = b_ext_i;
  assign ext_en_w[0]  = a_ext_en_i;
  assign ext_en_w[1]  = b_ext_en_i;
  assign oe_w[0]      = !pd_i && !oe_ba_ni;
  assign oe_w[1]      = !pd_i && oe_ab_i;
  assign sel_w[0]     = sel_ba_i;
  assign sel_w[1]     = sel_ab_i;
  assign cap_clk_w[0] = clk_ab_i;
  assign cap_clk_w[1] = clk_ba_i;

  for (genvar s = 0; s < NUM_BUS; s++) begin : g_bus
    localparam int unsigned O = NUM_BUS - 1 - s;

    // register loaded from this bus; it feeds the driver onto the other bus
    xcvr_store_reg #(.W(W)) u_cap (
      .clk_i  (cap_clk_w[s]),
      .rst_ni (rst_ni),
      .d_i    (bus_w[s]),
      .q_o    (cap_q[s])
    );

    xcvr_store_reg #(.W(W)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bus_w[s]),
      .q_o    (hold_q[s])
    );

    assign stored_w[s] = cap_q[O];

    xcvr_bus_resolve #(.W(W)) u_res (
      .x_ext_en_i (ext_en_w[s]),
      .x_ext_i    (ext_w[s]),
      .x_hold_i   (hold_q[s]),
      .x_oe_i     (oe_w[s]),
      .x_sel_i    (sel_w[s]),
      .x_stored_i (stored_w[s]),
      .y_ext_en_i (ext_en_w[O]),
      .y_ext_i    (ext_w[O]),
      .y_hold_i   (hold_q[O]),
      .y_oe_i     (oe_w[O]),
      .y_sel_i    (sel_w[O]),
      .y_stored_i (stored_w[O]),
      .x_bus_o    (bus_w[s])
    );

    xcvr_drive #(.W(W)) u_drv (
      .oe_i     (oe_w[s]),
      .sel_i    (sel_w[s]),
      .stored_i (stored_w[s]),
      .live_i   (bus_w[O]),
      .drv_o    (drv_w[s])
    );
  end

  assign a_drv_o = drv_w[0];
  assign a_oe_o  = oe_w[0];
  assign a_bus_o = bus_w[0];
  assign b_drv_o = drv_w[1];
  assign b_oe_o  = oe_w[1];
  assign b_bus_o = bus_w[1];
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pd_i,
  input logic         oe_ab_i,
  input logic         oe_ba_ni,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_ext_i,
  input logic         a_ext_en_i,
  input logic         b_ext_en_i,
  input logic [W-1:0] a_drv_o,
  input logic         a_oe_o,
  input logic [W-1:0] a_bus_o,
  input logic [W-1:0] b_drv_o,
  input logic         b_oe_o,
  input logic [W-1:0] b_bus_o
);
  assert_pd_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (!a_oe_o && !b_oe_o && a_drv_o == '0 && b_drv_o == '0));

  assert_ab_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ab_i |-> !b_oe_o);

  assert_ba_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ba_ni |-> !a_oe_o);

  assert_live_ab_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i && a_ext_en_i) |-> b_drv_o == a_ext_i);

  assert_bus_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_ext_en_i && !a_oe_o && $past(rst_ni)) |-> a_bus_o == $past(a_bus_o));

  assert_loop_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && b_oe_o && !sel_ab_i && !sel_ba_i && a_ext_en_i && !b_ext_en_i)
      |-> (b_bus_o == a_ext_i && a_drv_o == a_ext_i));
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/reg_bus_xcvr_bench.sv
`timescale 1ns/1ps
module reg_bus_xcvr_bench;
  localparam int CLK_PERIOD = 20;
  localparam int W = 8;

  logic         clk_i = 1'b0, rst_ni = 1'b0, pd_i = 1'b0;
  logic         clk_ab_i = 1'b0, clk_ba_i = 1'b0;
  logic         oe_ab_i = 1'b0, oe_ba_ni = 1'b1, sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic [W-1:0] a_ext_i = '0, b_ext_i = '0;
  logic         a_ext_en_i = 1'b0, b_ext_en_i = 1'b0;
  logic [W-1:0] a_drv_o, a_bus_o, b_drv_o, b_bus_o;
  logic         a_oe_o, b_oe_o;

  int checks = 0, errors = 0;
  logic [W-1:0] ref_ab = '0, ref_ba = '0, ref_ha = '0, ref_hb = '0;

  reg_bus_xcvr #(.W(W)) u_reg_bus_xcvr (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic en_b(); return !pd_i && oe_ab_i;  endfunction
  function automatic logic en_a(); return !pd_i && !oe_ba_ni; endfunction

  // A bus seen through B's side when B itself may be live-driven from A
  function automatic logic [W-1:0] exp_a_bus();
    if (a_ext_en_i) return a_ext_i;
    if (!en_a()) return ref_ha;
    if (sel_ba_i) return ref_ba;
    if (b_ext_en_i) return b_ext_i;
    if (!en_b()) return ref_hb;
    if (sel_ab_i) return ref_ab;
    return ref_ha;
  endfunction

  function automatic logic [W-1:0] exp_b_bus();
    if (b_ext_en_i) return b_ext_i;
    if (!en_b()) return ref_hb;
    if (sel_ab_i) return ref_ab;
    if (a_ext_en_i) return a_ext_i;
    if (!en_a()) return ref_ha;
    if (sel_ba_i) return ref_ba;
    return ref_hb;
  endfunction

  function automatic logic [W-1:0] exp_a_drv();
    if (!en_a()) return '0;
    return sel_ba_i ? ref_ba : exp_b_bus();
  endfunction

  function automatic logic [W-1:0] exp_b_drv();
    if (!en_b()) return '0;
    return sel_ab_i ? ref_ab : exp_a_bus();
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_ha <= '0;
      ref_hb <= '0;
    end else begin
      ref_ha <= exp_a_bus();
      ref_hb <= exp_b_bus();
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({7'd0, a_oe_o}, {7'd0, en_a()}, {ctx, " R2/R8 a_oe"});
    chk({7'd0, b_oe_o}, {7'd0, en_b()}, {ctx, " R2/R8 b_oe"});
    chk(a_drv_o, exp_a_drv(), {ctx, " R3/R4 a_drv"});
    chk(b_drv_o, exp_b_drv(), {ctx, " R3/R4 b_drv"});
    chk(a_bus_o, exp_a_bus(), {ctx, " R6/R7 a_bus"});
    chk(b_bus_o, exp_b_bus(), {ctx, " R6/R7 b_bus"});
  endtask

  task automatic pulse_ab();
    ref_ab = exp_a_bus();
    clk_ab_i = 1'b1; #1; clk_ab_i = 1'b0; #1;
  endtask

  task automatic pulse_ba();
    ref_ba = exp_b_bus();
    clk_ba_i = 1'b1; #1; clk_ba_i = 1'b0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk(a_bus_o, 8'h00, "R1 a_bus after reset");
    chk(b_bus_o, 8'h00, "R1 b_bus after reset");
    pd_i = 1'b0; oe_ab_i = 1'b1; oe_ba_ni = 1'b0; sel_ab_i = 1'b1; sel_ba_i = 1'b1; #1;
    chk(b_drv_o, 8'h00, "R1 A-to-B register zero");
    chk(a_drv_o, 8'h00, "R1 B-to-A register zero");

    // R5: capture while powered down and disabled
    @(negedge clk_i);
    pd_i = 1'b1; oe_ab_i = 1'b0; oe_ba_ni = 1'b1; sel_ab_i = 1'b0; sel_ba_i = 1'b0;
    a_ext_i = 8'h3C; a_ext_en_i = 1'b1; b_ext_i = 8'hC5; b_ext_en_i = 1'b1; #1;
    pulse_ab(); pulse_ba();
    @(negedge clk_i);
    pd_i = 1'b0; oe_ab_i = 1'b1; oe_ba_ni = 1'b0; sel_ab_i = 1'b1; sel_ba_i = 1'b1;
    a_ext_i = 8'h11; b_ext_i = 8'h22; #1;
    chk(b_drv_o, 8'h3C, "R5 A-to-B captured while disabled");
    chk(a_drv_o, 8'hC5, "R5 B-to-A captured while disabled");

    // R8: power-down overrides stored selects
    pd_i = 1'b1; #1;
    chk({7'd0, a_oe_o | b_oe_o}, 8'h00, "R8 enables off in power-down");
    chk(a_drv_o | b_drv_o, 8'h00, "R8 drivers zero in power-down");
    pd_i = 1'b0;

    // sweep all control combinations
    for (int i = 0; i < 128; i++) begin
      @(negedge clk_i);
      {pd_i, oe_ab_i, oe_ba_ni, sel_ab_i, sel_ba_i, a_ext_en_i, b_ext_en_i} = i[6:0];
      a_ext_i = 8'(i * 7 + 3);
      b_ext_i = ~8'(i * 13);
      #1; check_all("sweep pre");
      if (i % 3 == 0) pulse_ab();
      if (i % 5 == 0) pulse_ba();
      #1; check_all("sweep post-capture R5");
      @(posedge clk_i); #1; check_all("sweep post-edge R6");
    end

    // R7: both live and enabled, external source on A only
    @(negedge clk_i);
    pd_i = 1'b0; oe_ab_i = 1'b1; oe_ba_ni = 1'b0; sel_ab_i = 1'b0; sel_ba_i = 1'b0;
    a_ext_i = 8'h81; a_ext_en_i = 1'b1; b_ext_en_i = 1'b0; #1;
    chk(b_bus_o, 8'h81, "R7 A source reaches B");
    chk(a_drv_o, 8'h81, "R7 B reinforces A");
    @(negedge clk_i); a_ext_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(a_bus_o, 8'h81, "R7 A keeps last value");
    chk(b_bus_o, 8'h81, "R7 B keeps last value");
    // external on B only
    b_ext_i = 8'h5E; b_ext_en_i = 1'b1; #1;
    chk(a_bus_o, 8'h5E, "R7 B source reaches A");
    chk(b_drv_o, 8'h5E, "R7 A reinforces B");

    // R9: select switch without clock edge
    b_ext_en_i = 1'b0; a_ext_i = 8'h99; a_ext_en_i = 1'b1; #1;
    chk(b_drv_o, 8'h99, "R9 live before switch");
    sel_ab_i = 1'b1; #1;
    chk(b_drv_o, ref_ab, "R9 stored right after switch");
    oe_ab_i = 1'b0; #1;
    chk({7'd0, b_oe_o}, 8'h00, "R9 R2 disable without clock");

    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule